// File: doc/BRIEF.md
# Four-Bank Asynchronous Memory Controller with Wait States

This controller sits between a simple host request bus and a set of asynchronous memory devices spread over a 24-bit byte address space. The two most significant address bits select one of four equal 4-megabyte regions. Each region has its own active-low chip select, so each can hold a different kind of device.

Every region has its own access length, set as a 4-bit wait-state value that gives 1 to 16 strobe clocks. A per-region mode bit decides whether an external active-low ready input is honoured. When it is honoured, ready is first sampled on the last programmed strobe clock. While ready is inactive the strobe is held open, one clock at a time. After the strobe ends, chip select stays asserted for one more clock. During that clock the host acknowledge pulses and the captured read data is presented.

The host raises `req_valid` with the address, direction and write data, and holds them until it sees `ack`. It drops `req_valid` during the acknowledge clock. The timing configuration inputs are sampled when a request is accepted.

Top module: `bank_mem_ctrl`

## Requirements
- R1: After reset, all four `mem_cs_n` lines are high, `mem_we_n` and `mem_oe_n` are high, and `ack` is low.
- R2: During a cycle, exactly one chip select is low: bit `req_addr[23:22]` of `mem_cs_n` (bank 0 drives bit 0). While idle, all chip selects are high.
- R3: With ready honoured and active, or with ready ignored, the strobe (`mem_we_n` or `mem_oe_n` low) lasts exactly wait+1 clocks. Here wait is the bank's 4-bit field `cfg_wait[4*bank+3 : 4*bank]`.
- R4: When the bank's bit `cfg_rdy_en[bank]` is 1, ready is first sampled on the last programmed strobe clock. Each clock in which `mem_rdy_n` is high at that point adds one strobe clock.
- R5: When `cfg_rdy_en[bank]` is 0, `mem_rdy_n` has no effect on the strobe length, even if it is held high for the whole access.
- R6: `mem_addr` equals the accepted request address and stays stable while chip select is low.
- R7: The strobe is released one clock before chip select. During that extra clock chip select is still low and both strobes are high.
- R8: `ack` is high for exactly one clock, the clock after the strobe ends. For reads, `rdata` then holds the `mem_rdata` value present on the final strobe clock.
- R9: A read drives only `mem_oe_n` low and a write drives only `mem_we_n` low. During a write, `mem_wdata` carries the request's write data.
- R10: After the acknowledge clock, the controller returns to idle with all chip selects high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wait | input | 16 | Wait-state field per bank, 4 bits each, bank 0 in the low nibble |
| cfg_rdy_en | input | 4 | Per-bank enable for honouring the ready input |
| req_valid | input | 1 | Host request, held until ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Captured read data |
| mem_addr | output | 24 | Address to the memory devices |
| mem_wdata | output | 16 | Write data to the memory devices |
| mem_rdata | input | 16 | Read data from the memory devices |
| mem_cs_n | output | 4 | Active-low chip select per bank |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_rdy_n | input | 1 | Active-low external ready |

## Verification
Two things meet on the last programmed strobe clock: the wait-state count runs out, and ready is sampled. The same edge must either extend the strobe or capture read data and raise the acknowledge. The bench provokes this by keeping ready inactive for a chosen number of clocks past the programmed length, including zero, on banks with the mode bit set and clear and with wait values of 0 and 15. It judges the result by the strobe length it counts, the clock in which `ack` appears and the read data presented with it.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_HOLD   = 2'd2
    } bmc_state_e;

endpackage

// File: rtl/bmc_bank_decode.sv
module bmc_bank_decode #(
    parameter int ADDR_W    = 24,
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [BANK_W-1:0] bank_o
);
    // Banks are equal slices selected by the top address bits.
    assign bank_o = addr_i[ADDR_W-1 -: BANK_W];
endmodule

// File: rtl/bmc_timing_sel.sv
module bmc_timing_sel #(
    parameter int NUM_BANKS = 4,
    parameter int WS_W      = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic [NUM_BANKS*WS_W-1:0] cfg_wait_i,
    input  logic [NUM_BANKS-1:0]      cfg_rdy_en_i,
    input  logic [BANK_W-1:0]         bank_i,
    output logic [WS_W-1:0]           wait_o,
    output logic                      rdy_en_o
);
    logic [WS_W-1:0] wait_arr [NUM_BANKS];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_slice
        assign wait_arr[g] = cfg_wait_i[g*WS_W +: WS_W];
    end

    assign wait_o   = wait_arr[bank_i];
    assign rdy_en_o = cfg_rdy_en_i[bank_i];
endmodule

// File: rtl/bmc_cs_gen.sv
module bmc_cs_gen #(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              active_i,
    input  logic [BANK_W-1:0] bank_i,
    output logic [NUM_BANKS-1:0] cs_n_o
);
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cs
        assign cs_n_o[g] = !(active_i && (bank_i == BANK_W'(g)));
    end
endmodule

// File: rtl/bank_mem_ctrl.sv
module bank_mem_ctrl
    import bmc_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 16,
    parameter int NUM_BANKS = 4,
    parameter int WS_W      = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_BANKS*WS_W-1:0] cfg_wait,
    input  logic [NUM_BANKS-1:0]      cfg_rdy_en,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic                      ack,
    output logic [DATA_W-1:0]         rdata,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [DATA_W-1:0]         mem_wdata,
    input  logic [DATA_W-1:0]         mem_rdata,
    output logic [NUM_BANKS-1:0]      mem_cs_n,
    output logic                      mem_oe_n,
    output logic                      mem_we_n,
    input  logic                      mem_rdy_n
);
    localparam int BANK_W = $clog2(NUM_BANKS);

    typedef struct packed {
        bmc_state_e        state;
        logic [BANK_W-1:0] bank;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              write;
        logic [WS_W-1:0]   cnt;
        logic              rdy_en;
        logic [DATA_W-1:0] rdata;
        logic              ack;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [BANK_W-1:0] req_bank;
    logic [WS_W-1:0]   sel_wait;
    logic              sel_rdy_en;
    logic              cycle_act;
    logic              strobe_act;
    logic              stretch;

    bmc_bank_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_BANKS (NUM_BANKS)
    ) u_decode (
        .addr_i (req_addr),
        .bank_o (req_bank)
    );

    bmc_timing_sel #(
        .NUM_BANKS (NUM_BANKS),
        .WS_W      (WS_W)
    ) u_tsel (
        .cfg_wait_i   (cfg_wait),
        .cfg_rdy_en_i (cfg_rdy_en),
        .bank_i       (req_bank),
        .wait_o       (sel_wait),
        .rdy_en_o     (sel_rdy_en)
    );

    // Ready only matters on or after the final programmed strobe clock.
    assign stretch = ctrl_q.rdy_en && mem_rdy_n;

    always_comb begin
        ctrl_d     = ctrl_q;
        ctrl_d.ack = 1'b0;
        case (ctrl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    ctrl_d.state  = ST_ACCESS;
                    ctrl_d.bank   = req_bank;
                    ctrl_d.addr   = req_addr;
                    ctrl_d.wdata  = req_wdata;
                    ctrl_d.write  = req_write;
                    ctrl_d.cnt    = sel_wait;
                    ctrl_d.rdy_en = sel_rdy_en;
                end
            end
            ST_ACCESS: begin
                if (ctrl_q.cnt != '0) begin
                    ctrl_d.cnt = ctrl_q.cnt - 1'b1;
                end else if (!stretch) begin
                    ctrl_d.state = ST_HOLD;
                    ctrl_d.ack   = 1'b1;
                    if (!ctrl_q.write) begin
                        ctrl_d.rdata = mem_rdata;
                    end
                end
            end
            ST_HOLD: begin
                ctrl_d.state = ST_IDLE;
            end
            default: begin
                ctrl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{state: ST_IDLE, default: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign cycle_act  = (ctrl_q.state != ST_IDLE);
    assign strobe_act = (ctrl_q.state == ST_ACCESS);

    bmc_cs_gen #(
        .NUM_BANKS (NUM_BANKS)
    ) u_csgen (
        .active_i (cycle_act),
        .bank_i   (ctrl_q.bank),
        .cs_n_o   (mem_cs_n)
    );

    assign mem_addr  = ctrl_q.addr;
    assign mem_wdata = ctrl_q.wdata;
    assign mem_oe_n  = !(strobe_act && !ctrl_q.write);
    assign mem_we_n  = !(strobe_act && ctrl_q.write);
    assign ack       = ctrl_q.ack;
    assign rdata     = ctrl_q.rdata;

endmodule

// File: rtl/bank_mem_ctrl_chk.sv
module bank_mem_ctrl_chk #(
    parameter int ADDR_W    = 24,
    parameter int NUM_BANKS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_BANKS-1:0] mem_cs_n,
    input logic                 mem_oe_n,
    input logic                 mem_we_n,
    input logic [ADDR_W-1:0]    mem_addr,
    input logic                 ack
);
    logic cs_act;
    logic strb_act;
    assign cs_act   = !(&mem_cs_n);
    assign strb_act = !mem_oe_n || !mem_we_n;

    assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~mem_cs_n) <= 1);

    assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && $past(cs_act)) |-> $stable(mem_addr));

    assert_cs_outlasts_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strb_act) |-> cs_act);

    assert_ack_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    assert_ack_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (!strb_act && cs_act));

    assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    assert_strobe_within_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        strb_act |-> cs_act);

    assert_idle_after_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !cs_act);
endmodule

bind bank_mem_ctrl bank_mem_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .NUM_BANKS (NUM_BANKS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_cs_n (mem_cs_n),
    .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n),
    .mem_addr (mem_addr),
    .ack      (ack)
);

// File: tb/bank_mem_ctrl_bench.sv
module bank_mem_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_wait = '0;
    logic [3:0]  cfg_rdy_en = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        ack;
    logic [15:0] rdata;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic [3:0]  mem_cs_n;
    logic        mem_oe_n;
    logic        mem_we_n;
    logic        mem_rdy_n = 1'b0;

    int n_vec  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] mem_model(input logic [23:0] a);
        return a[15:0] ^ 16'h5A3C ^ {a[23:16], a[23:16]};
    endfunction

    assign mem_rdata = mem_model(mem_addr);

    bank_mem_ctrl u_bank_mem_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wait   (cfg_wait),
        .cfg_rdy_en (cfg_rdy_en),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .ack        (ack),
        .rdata      (rdata),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_cs_n   (mem_cs_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_rdy_n  (mem_rdy_n)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_cs(input logic [23:0] a);
        logic [3:0] v = 4'hF;
        v[a[23:22]] = 1'b0;
        return v;
    endfunction

    task automatic run_txn(input logic [23:0] a, input bit wr, input logic [15:0] wd,
                           input logic [3:0] ws, input bit en, input int ext);
        int  s = 0;
        int  exp_len;
        bit  done = 0;
        bit  bad_cs = 0, bad_addr = 0, bad_strb = 0, bad_wd = 0;
        logic [1:0] b = a[23:22];
        @(negedge clk);
        cfg_wait[b*4 +: 4] = ws;
        cfg_rdy_en[b]      = en;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = wd;
        exp_len   = int'(ws) + 1 + (en ? ext : 0);
        for (int i = 0; i < 200 && !done; i++) begin
            @(negedge clk);
            if (ack) begin
                done = 1;
                check(s == exp_len, "R3/R4/R5 strobe length", s, exp_len);
                check(mem_cs_n == exp_cs(a) && mem_oe_n && mem_we_n,
                      "R7 cs held past strobe", {mem_cs_n, mem_oe_n, mem_we_n},
                      {exp_cs(a), 2'b11});
                if (!wr) check(rdata == mem_model(a), "R8 read data", rdata, mem_model(a));
                req_valid = 1'b0;
            end else if (!mem_oe_n || !mem_we_n) begin
                s++;
                if (mem_cs_n != exp_cs(a)) bad_cs = 1;
                if (mem_addr != a) bad_addr = 1;
                if (mem_we_n != !wr || mem_oe_n != wr) bad_strb = 1;
                if (wr && mem_wdata != wd) bad_wd = 1;
                mem_rdy_n = en ? (s < int'(ws) + 1 + ext) : 1'b1;
            end
        end
        mem_rdy_n = 1'b0;
        check(done, "R8 ack seen", 32'(done), 1);
        check(!bad_cs, "R2 chip select", 32'(bad_cs), 0);
        check(!bad_addr, "R6 address stable", 32'(bad_addr), 0);
        check(!bad_strb, "R9 strobe direction", 32'(bad_strb), 0);
        check(!bad_wd, "R9 write data", 32'(bad_wd), 0);
        @(negedge clk);
        check(mem_cs_n == 4'hF && !ack, "R10 idle after ack / R8 single pulse",
              {mem_cs_n, ack}, {4'hF, 1'b0});
    endtask

    initial begin : watchdog
        while (cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin : stim
        logic [31:0] seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        check(mem_cs_n == 4'hF && mem_oe_n && mem_we_n && !ack, "R1 reset state",
              {mem_cs_n, mem_oe_n, mem_we_n, ack}, {4'hF, 3'b110});
        rst_n = 1'b1;
        @(negedge clk);
        // Directed corners: each bank, min and max wait, ready on and off.
        run_txn(24'h000010, 1'b0, 16'h0000, 4'd0,  1'b0, 0);
        run_txn(24'h400020, 1'b1, 16'hBEEF, 4'd0,  1'b1, 0);
        run_txn(24'h800030, 1'b0, 16'h0000, 4'd15, 1'b1, 3);
        run_txn(24'hC00040, 1'b0, 16'h0000, 4'd15, 1'b0, 5);  // R5 ready ignored
        run_txn(24'hFFFFFF, 1'b1, 16'h1234, 4'd3,  1'b1, 1);
        run_txn(24'h3FFFFF, 1'b0, 16'h0000, 4'd0,  1'b1, 4);  // R4 stretch at wait 0
        run_txn(24'h7FFFFE, 1'b0, 16'h0000, 4'd7,  1'b0, 0);
        // Random traffic.
        for (int k = 0; k < 60; k++) begin
            run_txn(24'($urandom), 1'($urandom), 16'($urandom), 4'($urandom),
                    1'($urandom), int'($urandom % 6));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule